// File: doc/BRIEF.md
# Locked Atomic Swap Sequencer

This block carries out a register-to-memory exchange instruction as one indivisible pair of bus cycles. It receives a 32-bit instruction word with a start strobe, the result of the condition check, and the two register-file operands: the address base and the source value. If the word is a valid exchange and the condition passes, the block reads the addressed location and then writes the captured source value back to the same address. A lock output stays high over both cycles so that an external arbiter cannot grant the bus to another master between them. The old memory value is returned as a write-back for the destination register.

The source operand is captured when the instruction is accepted, before the read starts. Source and destination may therefore name the same register, and memory still receives the register's old value. The read carries a cache-bypass marker, so it is always served by external memory. The write carries a cache-update marker, so a cached copy of the line is refreshed.

Both word and byte sizes are supported. A data abort on either bus cycle ends the sequence without any register write-back. Interrupts are held off while a sequence is in progress, and a one-cycle done pulse marks the end of every accepted instruction.

Top module: `swap_seq`

## Requirements
- R1: An instruction is accepted only when start is high, the sequencer is idle, and the word matches this pattern: bits 27:24 = 0001, bit 23 = 0, bits 21:20 = 00, bits 11:8 = 0000, bits 7:4 = 1001. Bit 22 selects the size, bits 19:16 give the address register, bits 15:12 the destination and bits 3:0 the source. Any other word produces no bus cycle and no done pulse.
- R2: If an accepted instruction has cond_pass low, no bus cycle is issued and mem_lock never rises. The block gives a done pulse one cycle later with wb_en low and aborted low.
- R3: A word exchange (bit 22 = 0) reads from rn_val, writes to the same address the rm_val captured at acceptance, with mem_be = 1111, and returns the old word on wb_data with wb_reg equal to bits 15:12. Later changes on rm_val have no effect.
- R4: Every bus request has mem_lock high. mem_lock is raised with the read request and falls only after the cycle in which the final bus cycle is acknowledged.
- R5: A byte exchange (bit 22 = 1) uses address bits 1:0 as the lane. The write has exactly that one mem_be bit set and carries the source byte in that lane. The lane's old byte is returned zero-extended on wb_data.
- R6: Every read cycle has mem_nocache high.
- R7: Every write cycle has mem_cache_upd high.
- R8: An abort on the read cycle ends the sequence with no write cycle, wb_en low and aborted high in the done cycle.
- R9: An abort on the write cycle gives wb_en low and aborted high in the done cycle.
- R10: done lasts exactly one cycle for each accepted instruction. irq_hold is high from the cycle after acceptance until the done cycle, and low once idle. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition evaluated true |
| rn_val | input | 32 | Address register value |
| rm_val | input | 32 | Source register value |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Bus lock for the read/write pair |
| mem_nocache | output | 1 | Read must bypass the cache |
| mem_cache_upd | output | 1 | Write refreshes a cached copy |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Bus cycle complete |
| mem_abort | input | 1 | Data abort, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Sequence ended by abort (with done) |
| wb_en | output | 1 | Destination write-back enable |
| wb_reg | output | 4 | Destination register index |
| wb_data | output | 32 | Destination write-back value |
| irq_hold | output | 1 | Interrupts held off |

## Verification
The assertions assume that the memory side raises mem_ack only while mem_req is high, that it holds mem_ack for a single cycle, and that mem_abort is meaningful only together with mem_ack. They also assume the bus never acknowledges a cycle the block did not request. The bench responder is a small memory that acknowledges after a chosen latency, lowers acknowledge in the cycle after, and raises abort only on the cycle picked for it. It never drives acknowledge without a pending request, so the stimulus keeps to these assumptions.

// File: rtl/swap_pkg.sv
package swap_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int REG_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        logic             is_byte;
        logic [REG_W-1:0] base_reg;
        logic [REG_W-1:0] dst_reg;
        logic [REG_W-1:0] src_reg;
    } swap_op_t;

    function automatic swap_op_t decode_swap(input logic [27:0] w);
        swap_op_t op;
        op.valid    = (w[27:24] == 4'b0001) && !w[23] && (w[21:20] == 2'b00)
                    && (w[11:8] == 4'b0000) && (w[7:4] == 4'b1001);
        op.is_byte  = w[22];
        op.base_reg = w[19:16];
        op.dst_reg  = w[15:12];
        op.src_reg  = w[3:0];
        return op;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic is_byte,
                                                   input logic [LANE_W-1:0] lane);
        logic [LANES-1:0] m;
        for (int l = 0; l < LANES; l++)
            m[l] = !is_byte || (LANE_W'(l) == lane);
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] spread_byte(input logic is_byte,
                                                      input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = v;
        if (is_byte)
            for (int l = 0; l < LANES; l++)
                r[l*BYTE_W +: BYTE_W] = v[BYTE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/swap_decode.sv
module swap_decode
    import swap_pkg::*;
(
    input  logic [27:0] body,
    output swap_op_t    op
);
    always_comb op = decode_swap(body);
endmodule

// File: rtl/swap_lane_pick.sv
module swap_lane_pick
    import swap_pkg::*;
(
    input  logic              is_byte,
    input  logic [LANE_W-1:0] lane,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] value
);
    logic [BYTE_W-1:0] lane_bytes [LANES];
    logic [BYTE_W-1:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        picked = lane_bytes[0];
        for (int l = 1; l < LANES; l++)
            if (LANE_W'(l) == lane) picked = lane_bytes[l];
        value = is_byte ? {{(WORD_W-BYTE_W){1'b0}}, picked} : word;
    end
endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
    import swap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              load_en,
    input  swap_op_t          op,
    input  logic [WORD_W-1:0] rn_val,
    input  logic [WORD_W-1:0] rm_val,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be,
    output logic [REG_W-1:0]  wb_reg,
    output logic [WORD_W-1:0] wb_data
);
    logic [WORD_W-1:0] addr_q, temp_q, load_q;
    logic [REG_W-1:0]  dst_q;
    logic              byte_q;
    logic [WORD_W-1:0] load_shaped;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            temp_q <= '0;
            load_q <= '0;
            dst_q  <= '0;
            byte_q <= 1'b0;
        end else begin
            if (capture) begin
                addr_q <= rn_val;
                temp_q <= rm_val;
                dst_q  <= op.dst_reg;
                byte_q <= op.is_byte;
            end
            if (load_en) load_q <= load_shaped;
        end
    end

    swap_lane_pick u_pick (
        .is_byte (byte_q),
        .lane    (addr_q[LANE_W-1:0]),
        .word    (mem_rdata),
        .value   (load_shaped)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = spread_byte(byte_q, temp_q);
    assign mem_be    = lane_mask(byte_q, addr_q[LANE_W-1:0]);
    assign wb_reg    = dst_q;
    assign wb_data   = load_q;

    p_byte_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && byte_q) |-> ($countones(mem_be) == 1));
    p_word_lanes_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !byte_q) |-> (mem_be == '1));
endmodule

// File: rtl/swap_fsm.sv
module swap_fsm
    import swap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic op_valid,
    input  logic cond_pass,
    input  logic mem_ack,
    input  logic mem_abort,
    output logic capture,
    output logic load_en,
    output logic mem_req,
    output logic mem_we,
    output logic mem_lock,
    output logic mem_nocache,
    output logic mem_cache_upd,
    output logic done,
    output logic aborted,
    output logic wb_en,
    output logic irq_hold
);
    seq_state_e state_q, state_d;
    logic ok_q, ok_d, abort_q, abort_d;

    always_comb begin
        state_d = state_q;
        ok_d    = ok_q;
        abort_d = abort_q;
        capture = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start && op_valid) begin
                capture = 1'b1;
                ok_d    = 1'b0;
                abort_d = 1'b0;
                state_d = cond_pass ? ST_READ : ST_FIN;
            end
            ST_READ: if (mem_ack) begin
                if (mem_abort) begin
                    abort_d = 1'b1;
                    state_d = ST_FIN;
                end else begin
                    load_en = 1'b1;
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: if (mem_ack) begin
                abort_d = mem_abort;
                ok_d    = !mem_abort;
                state_d = ST_FIN;
            end
            ST_FIN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ok_q    <= ok_d;
            abort_q <= abort_d;
        end
    end

    assign mem_req       = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we        = (state_q == ST_WRITE);
    assign mem_lock      = mem_req;
    assign mem_nocache   = (state_q == ST_READ);
    assign mem_cache_upd = (state_q == ST_WRITE);
    assign done          = (state_q == ST_FIN);
    assign aborted       = done && abort_q;
    assign wb_en         = done && ok_q;
    assign irq_hold      = (state_q != ST_IDLE);

    p_req_locked_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);
    p_lock_held_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_lock && !mem_ack) |=> mem_lock);
    p_read_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> mem_nocache);
    p_write_refresh_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_cache_upd);
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_wb_clean_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (done && !aborted));
    p_read_abort_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack && mem_abort) |=> !mem_req);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !irq_hold |-> !mem_lock);
endmodule

// File: rtl/swap_seq.sv
module swap_seq
    import swap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic        cond_pass,
    input  logic [31:0] rn_val,
    input  logic [31:0] rm_val,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_lock,
    output logic        mem_nocache,
    output logic        mem_cache_upd,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic        mem_ack,
    input  logic        mem_abort,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        aborted,
    output logic        wb_en,
    output logic [3:0]  wb_reg,
    output logic [31:0] wb_data,
    output logic        irq_hold
);
    swap_op_t op;
    logic     capture, load_en;
    logic     unused_cond;

    assign unused_cond = ^instr[31:28];

    swap_decode u_dec (
        .body (instr[27:0]),
        .op   (op)
    );

    swap_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .op_valid      (op.valid),
        .cond_pass     (cond_pass),
        .mem_ack       (mem_ack),
        .mem_abort     (mem_abort),
        .capture       (capture),
        .load_en       (load_en),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_lock      (mem_lock),
        .mem_nocache   (mem_nocache),
        .mem_cache_upd (mem_cache_upd),
        .done          (done),
        .aborted       (aborted),
        .wb_en         (wb_en),
        .irq_hold      (irq_hold)
    );

    swap_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .load_en   (load_en),
        .op        (op),
        .rn_val    (rn_val),
        .rm_val    (rm_val),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .wb_reg    (wb_reg),
        .wb_data   (wb_data)
    );
endmodule

// File: tb/tb_swap_seq.sv
`timescale 1ns/1ps
module tb_swap_seq;
    logic        clk = 1'b0, rst = 1'b1;
    logic        start = 1'b0, cond_pass = 1'b1;
    logic [31:0] instr = '0, rn_val = '0, rm_val = '0;
    logic        mem_req, mem_we, mem_lock, mem_nocache, mem_cache_upd;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0, mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, aborted, wb_en, irq_hold;
    logic [3:0]  wb_reg;
    logic [31:0] wb_data;

    always #2.5 clk = ~clk;

    swap_seq dut (.*);

    int vectors = 0, errors = 0;
    logic [31:0] mem [16];
    int  lat = 0;
    bit  ab_rd = 0, ab_wr = 0;
    int  cnt = 0;
    int  rd_seen = 0, wr_seen = 0, done_seen = 0;
    logic [31:0] wr_addr_seen, wr_data_seen, rd_addr_seen;
    logic [3:0]  wr_be_seen;
    bit  prev_lock = 0, prev_ack = 0, prev_done = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory responder
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0; mem_abort <= 1'b0; cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (cnt >= lat) begin
                cnt       <= 0;
                mem_ack   <= 1'b1;
                mem_abort <= mem_we ? ab_wr : ab_rd;
                mem_rdata <= mem[mem_addr[5:2]];
                if (mem_we && !ab_wr)
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) mem[mem_addr[5:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end else cnt <= cnt + 1;
        end else begin
            mem_ack <= 1'b0; mem_abort <= 1'b0;
        end
    end

    // per-cycle monitor
    always @(negedge clk) if (!rst) begin
        if (mem_req) begin
            chk(mem_lock, "R4 req without lock", {31'b0, mem_lock}, 32'h1);
            if (!mem_we) chk(mem_nocache, "R6 read bypass", {31'b0, mem_nocache}, 32'h1);
            else         chk(mem_cache_upd, "R7 write refresh", {31'b0, mem_cache_upd}, 32'h1);
        end
        if (prev_lock && !mem_lock)
            chk(prev_ack, "R4 lock dropped early", {31'b0, prev_ack}, 32'h1);
        if (prev_done) chk(!done, "R10 done width", {31'b0, done}, 32'h0);
        if (mem_req && mem_ack && !mem_we) begin rd_seen++; rd_addr_seen = mem_addr; end
        if (mem_req && mem_ack && mem_we) begin
            wr_seen++; wr_addr_seen = mem_addr; wr_data_seen = mem_wdata; wr_be_seen = mem_be;
        end
        if (done) done_seen++;
        prev_lock = mem_lock; prev_ack = mem_ack; prev_done = done;
    end

    function automatic logic [31:0] enc(input bit b, input logic [3:0] n, d, m);
        return {4'he, 4'b0001, 1'b0, b, 2'b00, n, d, 4'b0000, 4'b1001, m};
    endfunction

    task automatic run(input logic [31:0] iw, input bit cp, input logic [31:0] rn, rm,
                       input bit ar, aw, input int l, input bit restart);
        logic [31:0] old_w, exp_mem, exp_wb, wexp;
        bit ok_word, isb, got;
        int lane;
        ok_word = (iw[27:24] == 4'b0001) && !iw[23] && (iw[21:20] == 0)
                  && (iw[11:8] == 0) && (iw[7:4] == 4'b1001);
        isb   = iw[22];
        lane  = rn[1:0];
        old_w = mem[rn[5:2]];
        exp_wb  = isb ? {24'b0, old_w[lane*8 +: 8]} : old_w;
        exp_mem = old_w;
        if (isb) exp_mem[lane*8 +: 8] = rm[7:0]; else exp_mem = rm;
        wexp = isb ? {4{rm[7:0]}} : rm;
        lat = l; ab_rd = ar; ab_wr = aw;
        rd_seen = 0; wr_seen = 0; done_seen = 0;
        @(negedge clk);
        instr = iw; cond_pass = cp; rn_val = rn; rm_val = rm; start = 1'b1;
        @(negedge clk);
        rm_val = ~rm; rn_val = rn ^ 32'h10;
        start = restart;
        if (ok_word) chk(irq_hold, "R10 irq_hold after accept", {31'b0, irq_hold}, 32'h1);
        instr = restart ? enc(0, 4'h1, 4'h2, 4'h3) : iw;
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (done) got = 1; else @(negedge clk);
            start = 1'b0;
        end
        if (!ok_word) begin
            chk(!got, "R1 bad word ignored", {31'b0, got}, 32'h0);
            chk(rd_seen + wr_seen == 0, "R1 no bus", rd_seen + wr_seen, 0);
            return;
        end
        chk(got, "R10 done arrives", {31'b0, got}, 32'h1);
        if (!cp) begin
            chk(rd_seen + wr_seen == 0, "R2 no bus on cond fail", rd_seen + wr_seen, 0);
            chk(!wb_en && !aborted, "R2 no wb", {30'b0, wb_en, aborted}, 0);
        end else if (ar) begin
            chk(wr_seen == 0, "R8 no write after read abort", wr_seen, 0);
            chk(!wb_en && aborted, "R8 abort flags", {30'b0, wb_en, aborted}, 32'h1);
            chk(mem[rn[5:2]] == old_w, "R8 memory kept", mem[rn[5:2]], old_w);
        end else if (aw) begin
            chk(!wb_en && aborted, "R9 abort flags", {30'b0, wb_en, aborted}, 32'h1);
            chk(mem[rn[5:2]] == old_w, "R9 memory kept", mem[rn[5:2]], old_w);
        end else begin
            chk(rd_seen == 1 && wr_seen == 1, "R10 one read one write", {rd_seen[15:0], wr_seen[15:0]}, 32'h00010001);
            chk(rd_addr_seen == rn && wr_addr_seen == rn, "R3 address", wr_addr_seen, rn);
            chk(wb_en && !aborted, "R3 wb_en", {30'b0, wb_en, aborted}, 32'h2);
            chk(wb_reg == iw[15:12], "R3 wb_reg", {28'b0, wb_reg}, {28'b0, iw[15:12]});
            if (isb) begin
                chk(wb_data == exp_wb, "R5 byte load", wb_data, exp_wb);
                chk(wr_be_seen == (4'b1 << lane), "R5 lane enable", {28'b0, wr_be_seen}, 32'(1 << lane));
                chk(mem[rn[5:2]] == exp_mem, "R5 byte store", mem[rn[5:2]], exp_mem);
            end else begin
                chk(wb_data == exp_wb, "R3 word load", wb_data, exp_wb);
                chk(wr_be_seen == 4'hf, "R3 word enables", {28'b0, wr_be_seen}, 32'hf);
                chk(wr_data_seen == wexp, "R3 latched source", wr_data_seen, wexp);
                chk(mem[rn[5:2]] == exp_mem, "R3 word store", mem[rn[5:2]], exp_mem);
            end
        end
        @(negedge clk);
        chk(!done && !irq_hold, "R10 idle after done", {30'b0, done, irq_hold}, 0);
        chk(done_seen == 1, "R10 single done", done_seen, 1);
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA5000000 + i * 32'h01010101;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !mem_lock && !done && !wb_en && !irq_hold, "R10 reset state",
            {27'b0, mem_req, mem_lock, done, wb_en, irq_hold}, 0);
        run(enc(0, 4'h1, 4'h2, 4'h3), 1, 32'h0000_0008, 32'h1234_5678, 0, 0, 0, 0);
        run(enc(0, 4'h4, 4'h5, 4'h5), 1, 32'h0000_000C, 32'hCAFE_F00D, 0, 0, 2, 0);
        for (int ln = 0; ln < 4; ln++)
            run(enc(1, 4'h1, 4'h6, 4'h7), 1, 32'h0000_0010 + ln, 32'h0000_0050 + ln, 0, 0, ln, 0);
        run(enc(0, 4'h1, 4'h2, 4'h3), 0, 32'h0000_0014, 32'h1111_1111, 0, 0, 0, 0);
        run(enc(0, 4'h1, 4'h2, 4'h3) ^ 32'h0000_0020, 1, 32'h0000_0018, 32'h2222_2222, 0, 0, 0, 0);
        run(enc(0, 4'h1, 4'h2, 4'h3) ^ 32'h0080_0000, 1, 32'h0000_0018, 32'h2222_2222, 0, 0, 0, 0);
        run(enc(0, 4'h1, 4'h2, 4'h3), 1, 32'h0000_001C, 32'h3333_3333, 1, 0, 1, 0);
        run(enc(1, 4'h1, 4'h2, 4'h3), 1, 32'h0000_0021, 32'h0000_0044, 0, 1, 1, 0);
        run(enc(0, 4'h8, 4'h9, 4'hA), 1, 32'h0000_0024, 32'h5555_AAAA, 0, 0, 3, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule